// File: doc/BRIEF.md
# Banked 64-bit Leading-Digit Normalizer

This block left-justifies a 64-bit mantissa in a single combinational pass. It also reports how far the mantissa was moved. The shift is not built as one 64-position barrel shifter. Instead there are four banks of 32-bit shifter slices, and each slice moves its window by only 0 to 15 places. Every bank sees the operand already moved left by 16 more places than the bank above it. Within a bank, the top slice counts leading zeros over its 32-bit window, and all slices of that bank share the low four bits of that count.

A priority pick then chooses the first bank whose leading digit sits in its top 16 positions. That bank's output becomes the result. The reported shift is the bank number placed above the four in-bank bits. Lower banks are only partly built, because their missing low slices would only ever produce zeros.

A sign input supports two's complement mantissas. The operand is XORed with the sign before leading-digit detection, so for negative values the block counts leading ones. The data path always shifts the raw operand and fills with zeros. When the XORed operand is entirely zero, a flag is raised and the shift reads 63.

Top module: `nrm_norm64`

## Requirements
- R1: `norm_o` always equals `data_i` shifted left by `shift_o` places, with zeros entering at the least significant end; the sign never alters the shifted data.
- R2: With `sign_i` = 0 and a nonzero operand, `shift_o` equals the number of zero bits above the most significant 1 of `data_i`.
- R3: With `sign_i` = 1, `shift_o` equals the number of 1 bits above the most significant 0 of `data_i`.
- R4: `zero_o` is 1 exactly when `data_i` XOR {64{`sign_i`}} is all zero. In that case `shift_o` is 63 and `norm_o` is `data_i` shifted left by 63.
- R5: `shift_o[5:4]` holds the selected bank (shift divided by 16) and `shift_o[3:0]` the in-bank shift (shift modulo 16). This holds across the bank boundaries 15/16, 31/32 and 47/48.
- R6: When `zero_o` is 0, bit 63 of `norm_o` differs from `sign_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 64 | Mantissa to normalize |
| sign_i | input | 1 | 1 treats the mantissa as negative two's complement |
| norm_o | output | 64 | Left-justified mantissa, zero filled |
| shift_o | output | 6 | Applied shift: bank number above in-bank count |
| zero_o | output | 1 | Operand carries no significant digit |

## Verification
The block holds no state, so a wrong internal signal shows at the ports in the same evaluation as the operand that exposes it.

A wrong in-bank count or shared slice code shows up as `norm_o` no longer matching the operand shifted by `shift_o`. A wrong bank pick moves the result by a multiple of 16 and flips the upper two bits of `shift_o`. Single-bit operands at all 64 positions, operands at the bank boundaries, and negative operands together drive every bank, every slice code and both leading-digit conventions.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
    parameter int unsigned DATA_W = 64;
    parameter int unsigned SEG_W  = 16;

    function automatic int unsigned clog2_u(input int unsigned v);
        int unsigned r = 0;
        while ((32'd1 << r) < v) r++;
        return r;
    endfunction
endpackage

// File: rtl/nrm_lead_enc.sv
// Leading-one position within one slice window; all-zero window gives the maximum code.
module nrm_lead_enc #(
    parameter int unsigned WIN_W  = 32,
    parameter int unsigned CODE_W = 5
) (
    input  logic [WIN_W-1:0]  win_i,
    output logic [CODE_W-1:0] code_o
);
    always_comb begin
        logic hit;
        hit    = 1'b0;
        code_o = '1;
        for (int i = WIN_W - 1; i >= 0; i--) begin
            if (!hit && win_i[i]) begin
                code_o = CODE_W'(WIN_W - 1 - i);
                hit    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/nrm_slice.sv
// One shifter slice: 2*SEG_W window moved left, upper SEG_W bits kept.
module nrm_slice #(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned SH_W  = 5
) (
    input  logic [2*SEG_W-1:0] win_i,
    input  logic [SH_W-1:0]    sh_i,
    output logic [SEG_W-1:0]   hi_o
);
    always_comb hi_o = SEG_W'((win_i << sh_i) >> SEG_W);
endmodule

// File: rtl/nrm_bank.sv
// A row of slices fed by an operand pre-moved left by SEG_W*BANK_IDX.
module nrm_bank #(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned SEG_W    = 16,
    parameter int unsigned BANK_IDX = 0,
    localparam int unsigned N_SL    = DATA_W / SEG_W,
    localparam int unsigned SLICE_W = 2 * SEG_W,
    localparam int unsigned EXT_W   = DATA_W + SEG_W,
    localparam int unsigned CODE_W  = nrm_pkg::clog2_u(SLICE_W),
    localparam int unsigned LO_W    = nrm_pkg::clog2_u(SEG_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] xr_i,
    input  logic              pick_i,
    output logic [DATA_W-1:0] out_o,
    output logic [LO_W-1:0]   lo_o,
    output logic              qual_o
);
    logic [SLICE_W-1:0] enc_win;
    logic [CODE_W-1:0]  code;

    assign enc_win = SLICE_W'((xr_i << (SEG_W * BANK_IDX)) >> (DATA_W - SLICE_W));

    nrm_lead_enc #(.WIN_W(SLICE_W), .CODE_W(CODE_W)) enc_i (
        .win_i (enc_win),
        .code_o(code)
    );

    // leading digit inside the upper SEG_W positions of this bank
    assign qual_o = ~code[CODE_W-1];
    assign lo_o   = code[LO_W-1:0];

    for (genvar k = 0; k < N_SL; k++) begin : g_sl
        if (k + BANK_IDX >= N_SL) begin : g_empty
            // unpopulated position: its window would hold only fill zeros
            assign out_o[DATA_W-1-SEG_W*k -: SEG_W] = '0;
        end else begin : g_live
            logic [SLICE_W-1:0] win;
            logic [LO_W:0]      sh;
            assign win = SLICE_W'(({data_i, {SEG_W{1'b0}}} << (SEG_W * (BANK_IDX + k)))
                                  >> (EXT_W - SLICE_W));
            if (k == N_SL - 1 - BANK_IDX) begin : g_tail
                // lowest slice of the row: forced past SEG_W-1 when the row is not picked
                assign sh = {~pick_i, code[LO_W-1:0]};
            end else begin : g_body
                assign sh = {1'b0, code[LO_W-1:0]};
            end
            nrm_slice #(.SEG_W(SEG_W), .SH_W(LO_W + 1)) sl_i (
                .win_i(win),
                .sh_i (sh),
                .hi_o (out_o[DATA_W-1-SEG_W*k -: SEG_W])
            );
        end
    end
endmodule

// File: rtl/nrm_bank_pick.sv
// Lowest-index qualifying bank wins; none qualifying selects the last bank.
module nrm_bank_pick #(
    parameter int unsigned N_BANK = 4,
    localparam int unsigned BANK_W = nrm_pkg::clog2_u(N_BANK)
) (
    input  logic [N_BANK-1:0] qual_i,
    output logic [BANK_W-1:0] idx_o,
    output logic [N_BANK-1:0] pick_o,
    output logic              none_o
);
    always_comb begin
        idx_o = BANK_W'(N_BANK - 1);
        for (int i = N_BANK - 1; i >= 0; i--) begin
            if (qual_i[i]) idx_o = BANK_W'(i);
        end
    end
    assign pick_o = N_BANK'(1) << idx_o;
    assign none_o = ~|qual_i;
endmodule

// File: rtl/nrm_norm64.sv
module nrm_norm64 #(
    parameter int unsigned DATA_W = nrm_pkg::DATA_W,
    parameter int unsigned SEG_W  = nrm_pkg::SEG_W,
    localparam int unsigned N_BANK = DATA_W / SEG_W,
    localparam int unsigned BANK_W = nrm_pkg::clog2_u(N_BANK),
    localparam int unsigned LO_W   = nrm_pkg::clog2_u(SEG_W),
    localparam int unsigned CNT_W  = BANK_W + LO_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              sign_i,
    output logic [DATA_W-1:0] norm_o,
    output logic [CNT_W-1:0]  shift_o,
    output logic              zero_o
);
    logic [DATA_W-1:0] xr;
    logic [DATA_W-1:0] bank_out [N_BANK];
    logic [LO_W-1:0]   bank_lo  [N_BANK];
    logic [N_BANK-1:0] qual;
    logic [N_BANK-1:0] pick;
    logic [BANK_W-1:0] idx;

    assign xr = data_i ^ {DATA_W{sign_i}};

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        nrm_bank #(.DATA_W(DATA_W), .SEG_W(SEG_W), .BANK_IDX(b)) bank_i (
            .data_i(data_i),
            .xr_i  (xr),
            .pick_i(pick[b]),
            .out_o (bank_out[b]),
            .lo_o  (bank_lo[b]),
            .qual_o(qual[b])
        );
    end

    nrm_bank_pick #(.N_BANK(N_BANK)) pick_i (
        .qual_i(qual),
        .idx_o (idx),
        .pick_o(pick),
        .none_o(zero_o)
    );

    assign norm_o  = bank_out[idx];
    assign shift_o = {idx, bank_lo[idx]};
endmodule

// File: rtl/nrm_norm64_chk.sv
module nrm_norm64_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned CNT_W  = 6
) (
    input logic [DATA_W-1:0] data_i,
    input logic              sign_i,
    input logic [DATA_W-1:0] norm_o,
    input logic [CNT_W-1:0]  shift_o,
    input logic              zero_o
);
    always_comb begin
        logic [DATA_W-1:0] mag;
        mag = data_i ^ {DATA_W{sign_i}};
        if (!$isunknown({data_i, sign_i, norm_o, shift_o, zero_o})) begin
            // R1
            shift_fill_chk: assert (norm_o == (data_i << shift_o))
                else $error("shift_fill_chk");
            // R2 R3
            lead_pos_chk: assert (zero_o || (((mag << shift_o) >> (DATA_W - 1)) == 1
                                  && (mag >> (DATA_W - int'(shift_o))) == 0))
                else $error("lead_pos_chk");
            // R4
            zero_code_chk: assert ((zero_o == (mag == '0)) && (!zero_o || shift_o == '1))
                else $error("zero_code_chk");
            // R6
            top_bit_chk: assert (zero_o || norm_o[DATA_W-1] != sign_i)
                else $error("top_bit_chk");
        end
    end
endmodule

bind nrm_norm64 nrm_norm64_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .data_i (data_i),
    .sign_i (sign_i),
    .norm_o (norm_o),
    .shift_o(shift_o),
    .zero_o (zero_o)
);

// File: tb/nrm_norm64_tb_top.sv
module nrm_norm64_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] data;
    logic        sign;
    logic [63:0] norm;
    logic [5:0]  shift;
    logic        zero;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #4 clk = ~clk;

    nrm_norm64 dut_i (
        .data_i (data),
        .sign_i (sign),
        .norm_o (norm),
        .shift_o(shift),
        .zero_o (zero)
    );

    function automatic int ref_cnt(input logic [63:0] d, input logic s);
        logic [63:0] m = d ^ {64{s}};
        for (int i = 63; i >= 0; i--) if (m[i]) return 63 - i;
        return 63;
    endfunction

    task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] d, input logic s);
        @(negedge clk);
        data = d;
        sign = s;
        #1;
    endtask

    task automatic full_case(input string req, input logic [63:0] d, input logic s);
        int c;
        apply(d, s);
        c = ref_cnt(d, s);
        cmp({req, " shift"}, 64'(shift), 64'(c));
        cmp({req, " zero"}, 64'(zero), 64'((d ^ {64{s}}) == 0));
        cmp({req, " norm"}, norm, d << c);
    endtask

    task automatic t_idle;
        // R4: quiet operand right after reset
        full_case("R4 idle", 64'h0, 1'b0);
    endtask

    task automatic t_single_bits;
        // R1 R2: one set bit at every position
        for (int p = 0; p < 64; p++) full_case("R2", 64'h1 << p, 1'b0);
    endtask

    task automatic t_negative;
        // R3: leading ones counted for negative operands
        for (int p = 0; p < 64; p++) full_case("R3", ~(64'h1 << p), 1'b1);
        full_case("R3 mixed", 64'hFFF0_1234_5678_9ABC, 1'b1);
        // R1: sign does not change the shifted data
        full_case("R1 sign", 64'h0000_0F00_0000_0001, 1'b1);
    endtask

    task automatic t_zero;
        // R4: all-zero magnitude for both signs
        full_case("R4 pos", 64'h0, 1'b0);
        cmp("R4 pos code", 64'(shift), 64'd63);
        full_case("R4 neg", '1, 1'b1);
        cmp("R4 neg norm", norm, 64'h8000_0000_0000_0000);
    endtask

    task automatic t_bounds;
        // R5: bank number above in-bank shift at each bank edge
        int edges [6] = '{15, 16, 31, 32, 47, 48};
        foreach (edges[e]) begin
            apply(64'h1 << (63 - edges[e]) | 64'h1, 1'b0);
            cmp("R5 bank", 64'(shift[5:4]), 64'(edges[e] / 16));
            cmp("R5 low", 64'(shift[3:0]), 64'(edges[e] % 16));
        end
    endtask

    task automatic t_top_bit;
        // R6: result top bit opposite to the sign
        apply(64'h0000_0000_00C0_0000, 1'b0);
        cmp("R6 pos", 64'(norm[63]), 64'd1);
        apply(64'hFFFF_FFF8_0000_0000, 1'b1);
        cmp("R6 neg", 64'(norm[63]), 64'd0);
    endtask

    task automatic t_random;
        // R1 R2 R3: random operands with random leading-zero spans
        for (int n = 0; n < 300; n++) begin
            logic [63:0] d = {$urandom, $urandom};
            logic        s = n[0];
            d = d >> ($urandom % 64);
            if (s) d = ~d;
            full_case(s ? "R3 rnd" : "R2 rnd", d, s);
        end
    endtask

    initial begin
        data = '0;
        sign = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_single_bits();
        t_negative();
        t_zero();
        t_bounds();
        t_top_bit();
        t_random();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule